// File: doc/BRIEF.md
# Two-Bus Accumulator Machine Core

This block is a small accumulator processor. It has a hardwired sequencer and a datapath in which six word registers share two internal buses, called A and B. The registers are the program counter, the instruction register, the memory address and memory data registers, the accumulator and a Y operand latch. Each register has its own load strobe and its own drive strobe on each bus. The ALU takes one operand from the Y latch and the other directly from bus B, and it can return its result only over bus A. Every operation is therefore a short sequence of bus transfers, and each transfer takes one clock cycle.

An instruction is a single word. The opcode sits in the top four bits and a word address fills the rest. The core fetches an instruction, executes it and fetches the next one, until it decodes a halt. Memory is external and synchronous with a fixed latency:
- A read strobe in one cycle returns data on `mem_rdata` in the next cycle.
- A write strobe commits at the end of its cycle.

The memory port has no back-pressure and no handshake. Only the memory address and data registers ever face memory.

Top module: `twobus_acc_cpu`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `pc_o` and `acc_o` are 0, `halted` is 0 and neither memory strobe is asserted.
- R2: The fetch of each instruction issues `mem_rd` with `mem_addr` equal to the program counter, and the program counter then advances by one. The first read after reset goes to address 0 one cycle after reset is released, and `pc_o` reads 1 one cycle after that.
- R3: The ALU function code has 3 bits: 000 B+Y, 001 B, 010 B+1, 011 B<<1, 100 B−Y, 101 NOT B, 110 B−1, 111 B>>1 (logical). Y is the latched register and B is the bus value.
- R4: Opcode 1 (LOAD X) sets ACC to M[X].
- R5: Opcode 3 (ADD X) sets ACC to ACC+M[X], modulo 2^DW.
- R6: Opcode 4 (SUB X) sets ACC to ACC−M[X], modulo 2^DW. The accumulator is the minuend.
- R7: Opcode 2 (STORE X) makes exactly one write to address X with `mem_wdata` equal to ACC. ACC is unchanged.
- R8: Opcode 5 (JUMP X) makes the next fetch come from address X.
- R9: Opcodes 6 INC, 7 DEC, 8 SHL, 9 SHR and 10 NOT replace ACC with ACC+1, ACC−1, ACC<<1, ACC>>1 (logical) and bitwise NOT ACC. The address field is ignored.
- R10: Opcode 0 (HALT) raises `halted`, which stays high until reset. While halted there is no memory traffic and the PC and ACC hold.
- R11: In every cycle at most one source drives bus A (a register or the ALU) and at most one register drives bus B.
- R12: `mem_rd` and `mem_wr` are never asserted together. Data read is taken into the memory data register in the cycle after the read strobe.
- R13: Opcodes 11 to 15 change nothing except advancing the PC to the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | DW-4 | Word address, taken from the memory address register |
| mem_wdata | output | DW | Write data, taken from the memory data register |
| mem_rdata | input | DW | Read data, valid in the cycle after `mem_rd` |
| acc_o | output | DW | Accumulator contents |
| pc_o | output | DW-4 | Program counter, address bits |
| halted | output | 1 | High once a HALT has executed |

## Verification
The bench builds the core with the default DW=16. This gives 12-bit addresses, and the bench maps 32 words of memory. Sixteen-bit operands let short vectors reach the wrap points directly: 0xFFFF+2, 0−1, 5−9 and INC of 0xFFFF. They also let a shift push bit 15 out, or pull a zero into it, in a single instruction. The small memory keeps whole programs (load, operate, store, halt) cheap to reload between vectors. It also keeps the sequence of read addresses short enough to compare in full.

// File: rtl/twobus_pkg.sv
package twobus_pkg;
  localparam int NREG = 6;
  localparam int OPW  = 4;

  typedef enum logic [2:0] {
    R_PC = 3'd0, R_IR = 3'd1, R_MAR = 3'd2, R_MDR = 3'd3, R_ACC = 3'd4, R_Y = 3'd5
  } reg_e;

  typedef enum logic [2:0] {
    F_ADD  = 3'b000, F_PASS = 3'b001, F_INC = 3'b010, F_SHL = 3'b011,
    F_SUB  = 3'b100, F_NOT  = 3'b101, F_DEC = 3'b110, F_SHR = 3'b111
  } alu_fn_e;

  localparam logic [OPW-1:0] OP_HALT  = 4'd0;
  localparam logic [OPW-1:0] OP_LOAD  = 4'd1;
  localparam logic [OPW-1:0] OP_STORE = 4'd2;
  localparam logic [OPW-1:0] OP_ADD   = 4'd3;
  localparam logic [OPW-1:0] OP_SUB   = 4'd4;
  localparam logic [OPW-1:0] OP_JUMP  = 4'd5;
  localparam logic [OPW-1:0] OP_INC   = 4'd6;
  localparam logic [OPW-1:0] OP_DEC   = 4'd7;
  localparam logic [OPW-1:0] OP_SHL   = 4'd8;
  localparam logic [OPW-1:0] OP_SHR   = 4'd9;
  localparam logic [OPW-1:0] OP_NOT   = 4'd10;

  typedef struct packed {
    logic [NREG-1:0] a_in;
    logic [NREG-1:0] a_out;
    logic [NREG-1:0] b_in;
    logic [NREG-1:0] b_out;
    logic            alu_a_out;
    alu_fn_e         fn;
    logic            mem_rd;
    logic            mem_wr;
    logic            mdr_take;
  } ctl_t;
endpackage

// File: rtl/twobus_alu.sv
module twobus_alu import twobus_pkg::*; #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] y_in,
  input  alu_fn_e       fn,
  output logic [DW-1:0] res
);
  always_comb begin
    unique case (fn)
      F_ADD:   res = b_in + y_in;
      F_PASS:  res = b_in;
      F_INC:   res = b_in + 1'b1;
      F_SHL:   res = b_in << 1;
      F_SUB:   res = b_in - y_in;
      F_NOT:   res = ~b_in;
      F_DEC:   res = b_in - 1'b1;
      F_SHR:   res = b_in >> 1;
      default: res = b_in;
    endcase
  end
endmodule

// File: rtl/twobus_ctrl.sv
module twobus_ctrl import twobus_pkg::*; (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op,
  output ctl_t           ctl,
  output logic           halted
);
  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_F3, S_X0, S_X1, S_X2, S_X3, S_X4, S_HALT
  } st_e;

  st_e st_q, st_d;

  function automatic alu_fn_e unary_fn(input logic [OPW-1:0] o);
    case (o)
      OP_INC:  return F_INC;
      OP_DEC:  return F_DEC;
      OP_SHL:  return F_SHL;
      OP_SHR:  return F_SHR;
      default: return F_NOT;
    endcase
  endfunction

  logic is_mem_op, is_unary;
  assign is_mem_op = (op == OP_LOAD) || (op == OP_STORE) || (op == OP_ADD) || (op == OP_SUB);
  assign is_unary  = (op >= OP_INC) && (op <= OP_NOT);

  always_comb begin
    ctl    = '0;
    ctl.fn = F_PASS;
    st_d   = st_q;
    unique case (st_q)
      S_F0: begin
        ctl.a_out[R_PC] = 1'b1; ctl.a_in[R_MAR] = 1'b1; st_d = S_F1;
      end
      S_F1: begin
        ctl.mem_rd = 1'b1;
        ctl.b_out[R_PC] = 1'b1; ctl.fn = F_INC; ctl.alu_a_out = 1'b1; ctl.a_in[R_PC] = 1'b1;
        st_d = S_F2;
      end
      S_F2: begin
        ctl.mdr_take = 1'b1; st_d = S_F3;
      end
      S_F3: begin
        ctl.a_out[R_MDR] = 1'b1; ctl.a_in[R_IR] = 1'b1; st_d = S_X0;
      end
      S_X0: begin
        st_d = S_F0;
        if (op == OP_HALT) begin
          st_d = S_HALT;
        end else if (is_mem_op) begin
          ctl.a_out[R_IR] = 1'b1; ctl.a_in[R_MAR] = 1'b1; st_d = S_X1;
        end else if (op == OP_JUMP) begin
          ctl.a_out[R_IR] = 1'b1; ctl.a_in[R_PC] = 1'b1;
        end else if (is_unary) begin
          ctl.b_out[R_ACC] = 1'b1; ctl.fn = unary_fn(op);
          ctl.alu_a_out = 1'b1; ctl.a_in[R_ACC] = 1'b1;
        end
      end
      S_X1: begin
        if (op == OP_STORE) begin
          ctl.a_out[R_ACC] = 1'b1; ctl.a_in[R_MDR] = 1'b1;
        end else begin
          ctl.mem_rd = 1'b1;
        end
        st_d = S_X2;
      end
      S_X2: begin
        if (op == OP_STORE) begin
          ctl.mem_wr = 1'b1; st_d = S_F0;
        end else begin
          ctl.mdr_take = 1'b1;
          if (op == OP_ADD) begin
            ctl.a_out[R_ACC] = 1'b1; ctl.a_in[R_Y] = 1'b1;
          end
          st_d = S_X3;
        end
      end
      S_X3: begin
        st_d = S_F0;
        if (op == OP_LOAD) begin
          ctl.a_out[R_MDR] = 1'b1; ctl.a_in[R_ACC] = 1'b1;
        end else if (op == OP_ADD) begin
          ctl.b_out[R_MDR] = 1'b1; ctl.fn = F_ADD;
          ctl.alu_a_out = 1'b1; ctl.a_in[R_ACC] = 1'b1;
        end else begin
          ctl.a_out[R_MDR] = 1'b1; ctl.a_in[R_Y] = 1'b1; st_d = S_X4;
        end
      end
      S_X4: begin
        ctl.b_out[R_ACC] = 1'b1; ctl.fn = F_SUB;
        ctl.alu_a_out = 1'b1; ctl.a_in[R_ACC] = 1'b1; st_d = S_F0;
      end
      S_HALT: st_d = S_HALT;
      default: st_d = S_F0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_F0;
    else        st_q <= st_d;
  end

  assign halted = (st_q == S_HALT);
endmodule

// File: rtl/twobus_datapath.sv
module twobus_datapath import twobus_pkg::*; #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] pc_q,
  output logic [DW-1:0] ir_q,
  output logic [DW-1:0] mar_q,
  output logic [DW-1:0] mdr_q,
  output logic [DW-1:0] acc_q
);
  localparam int AW = DW - OPW;

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] src  [NREG];
  logic [DW-1:0] a_bus, b_bus, alu_res;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == int'(R_IR)) begin : g_addr_only
      assign src[i] = {{OPW{1'b0}}, regs[i][AW-1:0]};
    end else begin : g_full
      assign src[i] = regs[i];
    end

    if (i == int'(R_MDR)) begin : g_mdr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            regs[i] <= '0;
        else if (ctl.mdr_take) regs[i] <= mem_rdata;
        else if (ctl.a_in[i])  regs[i] <= a_bus;
        else if (ctl.b_in[i])  regs[i] <= b_bus;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           regs[i] <= '0;
        else if (ctl.a_in[i]) regs[i] <= a_bus;
        else if (ctl.b_in[i]) regs[i] <= b_bus;
      end
    end
  end

  always_comb begin
    a_bus = ctl.alu_a_out ? alu_res : '0;
    b_bus = '0;
    for (int i = 0; i < NREG; i++) begin
      if (ctl.a_out[i]) a_bus = a_bus | src[i];
      if (ctl.b_out[i]) b_bus = b_bus | src[i];
    end
  end

  twobus_alu #(.DW(DW)) u_alu (
    .b_in(b_bus), .y_in(regs[R_Y]), .fn(ctl.fn), .res(alu_res)
  );

  assign pc_q  = regs[R_PC];
  assign ir_q  = regs[R_IR];
  assign mar_q = regs[R_MAR];
  assign mdr_q = regs[R_MDR];
  assign acc_q = regs[R_ACC];
endmodule

// File: rtl/twobus_acc_cpu.sv
module twobus_acc_cpu import twobus_pkg::*; #(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DW-OPW-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic [DW-1:0]     acc_o,
  output logic [DW-OPW-1:0] pc_o,
  output logic              halted
);
  localparam int AW = DW - OPW;

  ctl_t          ctl;
  logic [DW-1:0] pc_q, ir_q, mar_q, mdr_q, acc_q;
  logic [NREG:0] a_drv;
  logic [NREG-1:0] b_drv;

  twobus_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .op(ir_q[DW-1:AW]), .ctl(ctl), .halted(halted)
  );

  twobus_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .mem_rdata(mem_rdata),
    .pc_q(pc_q), .ir_q(ir_q), .mar_q(mar_q), .mdr_q(mdr_q), .acc_q(acc_q)
  );

  assign a_drv     = {ctl.alu_a_out, ctl.a_out};
  assign b_drv     = ctl.b_out;
  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;
  assign mem_addr  = mar_q[AW-1:0];
  assign mem_wdata = mdr_q;
  assign acc_o     = acc_q;
  assign pc_o      = pc_q[AW-1:0];
endmodule

// File: rtl/twobus_chk.sv
module twobus_chk #(
  parameter int DW = 16,
  parameter int NR = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] acc_o,
  input logic          halted,
  input logic          mdr_take,
  input logic [NR:0]   a_drv,
  input logic [NR-1:0] b_drv
);
  // R11
  bus_a_single_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(a_drv));
  // R11
  bus_b_single_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(b_drv));
  // R12
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  // R12
  rd_then_take_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> mdr_take);
  // R7
  store_data_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> mem_wdata == acc_o);
  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted && $stable(acc_o));
  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) halted |-> !mem_rd && !mem_wr);
endmodule

bind twobus_acc_cpu twobus_chk #(.DW(DW), .NR(twobus_pkg::NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
  .acc_o(acc_o), .halted(halted), .mdr_take(ctl.mdr_take), .a_drv(a_drv), .b_drv(b_drv)
);

// File: tb/tb_twobus_acc_cpu.sv
`timescale 1ns/1ps
module tb_twobus_acc_cpu;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_rd, mem_wr, halted;
  logic [AW-1:0] mem_addr, pc_o;
  logic [DW-1:0] mem_wdata, mem_rdata, acc_o;

  always #5 clk = ~clk;

  twobus_acc_cpu #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .acc_o(acc_o), .pc_o(pc_o), .halted(halted)
  );

  // memory model: 32 words, one-cycle read latency
  logic [DW-1:0] mem [32];
  logic          ld_en = 1'b0;
  logic [4:0]    ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] rdata_q;
  logic [AW-1:0] rlog [16];
  int            nlog, nwr, late;

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_wr) mem[mem_addr[4:0]] <= mem_wdata;
    if (mem_rd) rdata_q <= mem[mem_addr[4:0]];
    if (!rst_n) begin
      nlog <= 0; nwr <= 0; late <= 0;
    end else begin
      if (mem_rd && nlog < 16) begin rlog[nlog] <= mem_addr; nlog <= nlog + 1; end
      if (mem_wr) nwr <= nwr + 1;
      if (halted && (mem_rd || mem_wr)) late <= late + 1;
    end
  end
  assign mem_rdata = rdata_q;

  int nchk = 0, nfail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  task automatic poke(input int a, input logic [DW-1:0] d);
    @(negedge clk); ld_en = 1'b1; ld_addr = 5'(a); ld_data = d;
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic clear_mem();
    rst_n = 1'b0;
    for (int i = 0; i < 32; i++) poke(i, '0);
  endtask

  task automatic go_and_wait(input string tag);
    int n = 0;
    @(negedge clk); rst_n = 1'b1;
    while (!halted && n < 500) begin @(negedge clk); n++; end
    if (!halted) begin
      nchk++; nfail++;
      $display("FAIL %s R10 halted actual=0 expected=1", tag);
    end
  endtask

  function automatic logic [DW-1:0] model(input logic [3:0] op, input logic [DW-1:0] a,
                                          input logic [DW-1:0] b);
    case (op)
      4'd1:    return b;            // R4
      4'd2:    return a;            // R7
      4'd3:    return a + b;        // R5
      4'd4:    return a - b;        // R6
      4'd6:    return a + 1'b1;     // R9
      4'd7:    return a - 1'b1;
      4'd8:    return a << 1;
      4'd9:    return a >> 1;
      4'd10:   return ~a;
      default: return a;            // R13
    endcase
  endfunction

  // {op, a, b}: program LOAD 16; op 17; STORE 18; HALT with M16=a, M17=b
  localparam logic [35:0] VEC [NV] = '{
    {4'd3,  16'd100,  16'd23},
    {4'd3,  16'hFFFF, 16'd2},
    {4'd4,  16'd100,  16'd23},
    {4'd4,  16'd5,    16'd9},
    {4'd1,  16'h1234, 16'hBEEF},
    {4'd2,  16'hA5A5, 16'h0001},
    {4'd6,  16'hFFFF, 16'h7777},
    {4'd7,  16'h0000, 16'h7777},
    {4'd8,  16'h8001, 16'h0000},
    {4'd9,  16'h8001, 16'h0000},
    {4'd10, 16'h00F0, 16'h0000},
    {4'd12, 16'h4321, 16'h1111}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] exp;
    logic [AW-1:0] pc_hold;
    // reset state
    repeat (3) @(negedge clk);
    chk("R1 acc", acc_o, 0);
    chk("R1 pc", pc_o, 0);
    chk("R1 strobes", {mem_rd, mem_wr, halted}, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      clear_mem();
      poke(0, ins(4'd1, 12'd16));
      poke(1, ins(VEC[v][35:32], 12'd17));
      poke(2, ins(4'd2, 12'd18));
      poke(3, ins(4'd0, 12'd0));
      poke(16, VEC[v][31:16]);
      poke(17, VEC[v][15:0]);
      go_and_wait($sformatf("vec%0d", v));
      exp = model(VEC[v][35:32], VEC[v][31:16], VEC[v][15:0]);
      chk($sformatf("R3 vec%0d op%0d stored", v, VEC[v][35:32]), mem[18], exp);
      chk($sformatf("R3 vec%0d acc", v), acc_o, exp);
      chk($sformatf("R2 vec%0d pc", v), pc_o, 4);
      chk($sformatf("R7 vec%0d writes", v), nwr, (VEC[v][35:32] == 4'd2) ? 2 : 1);
    end

    // fetch timing right after reset
    clear_mem();
    poke(0, ins(4'd13, 12'd0));
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2 first read strobe", mem_rd, 1);
    chk("R2 first read addr", mem_addr, 0);
    @(negedge clk);
    chk("R2 pc advanced", pc_o, 1);

    // JUMP program: LOAD 16; JUMP 3; INC; STORE 18; HALT
    clear_mem();
    poke(0, ins(4'd1, 12'd16));
    poke(1, ins(4'd5, 12'd3));
    poke(2, ins(4'd6, 12'd0));
    poke(3, ins(4'd2, 12'd18));
    poke(4, ins(4'd0, 12'd0));
    poke(16, 16'h0042);
    go_and_wait("jump");
    chk("R8 skipped INC", mem[18], 16'h0042);
    chk("R8 read count", nlog, 5);
    chk("R2 read0", rlog[0], 0);
    chk("R4 read1", rlog[1], 16);
    chk("R2 read2", rlog[2], 1);
    chk("R8 read3", rlog[3], 3);
    chk("R8 read4", rlog[4], 4);

    // halt stays quiet
    pc_hold = pc_o;
    repeat (20) @(negedge clk);
    chk("R10 still halted", halted, 1);
    chk("R10 no traffic", late, 0);
    chk("R10 pc hold", pc_o, pc_hold);
    chk("R10 acc hold", acc_o, 16'h0042);

    // reset during a run
    clear_mem();
    poke(0, ins(4'd1, 12'd16));
    poke(1, ins(4'd6, 12'd0));
    poke(2, ins(4'd5, 12'd1));
    poke(16, 16'h0100);
    @(negedge clk); rst_n = 1'b1;
    repeat (12) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset acc", acc_o, 0);
    chk("R1 mid reset pc", pc_o, 0);
    chk("R1 mid reset strobes", {mem_rd, mem_wr, halted}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule